// File: doc/BRIEF.md
# Baseline-Corrected Intensity Sequencer

This block turns a stream of digitised pickup samples into a single baseline-corrected intensity figure per beam shot. Software first arms it. The next external sync pulse opens a baseline window, in which the quiet level ahead of the beam is summed over 2^L accepted samples. A beam window of the same length follows at once. When the beam window closes, the block presents the beam sum minus the baseline sum for one cycle and drops back to idle. Another shot needs a fresh arm.

While the beam window is open, every accepted sample has the per-sample baseline (baseline sum arithmetically shifted right by L) subtracted from it. The corrected value goes to an output stream intended for waveform storage. A programmable decimation keeps only every first, second, fourth or eighth corrected sample. The window length and the decimation are captured when the trigger is taken, so later changes to those inputs do not disturb a measurement already running. A sticky flag records any sync pulse that arrives while the block is not armed.

Both sample interfaces are valid/ready. A sample is taken on a cycle where `smp_valid` and `smp_ready` are both high. Outside the two windows, `smp_ready` is high and samples are discarded. During the baseline window, `smp_ready` is high. During the beam window, `smp_ready` is low exactly when a corrected sample is waiting and `cor_ready` is low. This is how downstream back-pressure holds off the source. A waiting corrected sample keeps `cor_valid` high and `cor_data` unchanged until `cor_ready` accepts it.

Top module: `bci_sequencer`

## Requirements
- R1: A one-cycle `arm_req` while idle makes `armed` high from the next cycle. `arm_req` in any other state has no effect on the state.
- R2: `beam_sync` while armed makes `armed` low and `busy` high from the next cycle. The block then accepts 2^L baseline samples followed by 2^L beam samples. L is `win_log2` captured at the trigger and limited to `MAX_LOG2`.
- R3: One cycle after the last beam sample is accepted, `res_valid` is high for exactly one cycle. `res_intensity` then equals the beam-window sum minus the baseline-window sum, both over signed samples.
- R4: Each emitted `cor_data` equals the beam sample minus floor(baseline sum / 2^L), as a signed value one bit wider than the sample.
- R5: `dec_sel` values 0, 1, 2 and 3 keep the beam samples whose index within the window (counting from 0) is a multiple of 1, 2, 4 and 8 respectively. The kept value appears on `cor_valid`/`cor_data` one cycle after its sample is accepted.
- R6: While `cor_valid` is high and `cor_ready` low, `cor_data` is held unchanged. During the beam window, `smp_ready` is low exactly in that situation. In all other cases `smp_ready` is high.
- R7: After the beam window ends, `busy` and `armed` are low. A `beam_sync` before the next `arm_req` starts nothing.
- R8: `beam_sync` while not armed (idle or busy) sets `missed_trig`. The flag stays set until an `arm_req` taken in idle without a simultaneous `beam_sync`.
- R9: After reset, `armed`, `busy`, `missed_trig`, `cor_valid` and `res_valid` are low and `smp_ready` is high.
- R10: Changing `win_log2` or `dec_sel` while busy has no effect on the window in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_req | input | 1 | Software arm pulse |
| beam_sync | input | 1 | External sync trigger pulse |
| win_log2 | input | LOG2_W | Window length exponent L |
| dec_sel | input | 2 | Decimation select (keep 1 of 2^dec_sel) |
| smp_valid | input | 1 | Input sample valid |
| smp_ready | output | 1 | Input sample ready |
| smp_data | input | SAMPLE_W | Signed input sample |
| cor_valid | output | 1 | Corrected sample valid |
| cor_ready | input | 1 | Corrected sample ready |
| cor_data | output | SAMPLE_W+1 | Signed baseline-corrected sample |
| res_valid | output | 1 | Result strobe |
| res_intensity | output | ACC_W+1 | Beam sum minus baseline sum |
| armed | output | 1 | Waiting for trigger |
| busy | output | 1 | Baseline or beam window open |
| missed_trig | output | 1 | Sticky ignored-trigger flag |

## Verification
The bench runs one shot with a full-rate source and an always-ready sink and small windows, which pins down the window counting and the timing of the result strobe. Other shots use random gaps on `smp_valid` together with a slow or stalled `cor_ready`. These separate correct stream back-pressure from dropped or duplicated samples. Each decimation setting is run, and so is an oversized `win_log2` that must be limited. Negative and mixed-sign samples show whether the baseline subtraction floors rather than truncates. Sync pulses arriving before arming, mid-window and after completion, together with configuration changes mid-shot, check the trigger filtering and the capture of the configuration.

// File: rtl/bci_pkg.sv
package bci_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BASE  = 2'd2,
    ST_BEAM  = 2'd3
  } seq_state_e;

  // mask selecting the low bits that must be zero for a kept sample
  function automatic logic [2:0] keep_mask(input logic [1:0] sel);
    logic [3:0] m;
    m = (4'd1 << sel) - 4'd1;
    return m[2:0];
  endfunction
endpackage

// File: rtl/bci_ctrl.sv
module bci_ctrl
  import bci_pkg::*;
#(
  parameter int MAX_LOG2 = 10,
  parameter int LOG2_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic              beam_sync,
  input  logic [LOG2_W-1:0] win_log2,
  input  logic [1:0]        dec_sel,
  input  logic              accept,
  output seq_state_e        state,
  output logic [LOG2_W-1:0] l_q,
  output logic [1:0]        dec_q,
  output logic              start,
  output logic              done,
  output logic              missed
);
  localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [LOG2_W-1:0] l_in;
  logic [32:0]       len_m1;
  logic              at_last;

  assign l_in     = (win_log2 > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : win_log2;
  assign len_m1   = (33'd1 << l_q) - 33'd1;
  assign last_idx = len_m1[CNT_W-1:0];
  assign at_last  = (cnt == last_idx);
  assign start    = (state == ST_ARMED) && beam_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      l_q    <= '0;
      dec_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (arm_req) state <= ST_ARMED;
        end
        ST_ARMED: begin
          if (beam_sync) begin
            state <= ST_BASE;
            cnt   <= '0;
            l_q   <= l_in;
            dec_q <= dec_sel;
          end
        end
        ST_BASE: begin
          if (accept) begin
            if (at_last) begin
              state <= ST_BEAM;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_BEAM: begin
          if (accept) begin
            if (at_last) begin
              state <= ST_IDLE;
              cnt   <= '0;
              done  <= 1'b1;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // sticky flag: a set request outranks the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      missed <= 1'b0;
    end else if (beam_sync && (state != ST_ARMED)) begin
      missed <= 1'b1;
    end else if (arm_req && (state == ST_IDLE)) begin
      missed <= 1'b0;
    end
  end
endmodule

// File: rtl/bci_window_acc.sv
module bci_window_acc #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 27
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] din,
  output logic [ACC_W-1:0]    sum
);
  logic [ACC_W-1:0] din_ext;

  assign din_ext = {{(ACC_W - SAMPLE_W){din[SAMPLE_W-1]}}, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
    end else if (clr) begin
      sum <= '0;
    end else if (en) begin
      sum <= sum + din_ext;
    end
  end
endmodule

// File: rtl/bci_corr_stream.sv
module bci_corr_stream
  import bci_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 27,
  parameter int LOG2_W   = 4,
  localparam int OUT_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                take,
  input  logic [LOG2_W-1:0]   l_q,
  input  logic [1:0]          dec_q,
  input  logic [ACC_W-1:0]    base_sum,
  input  logic [SAMPLE_W-1:0] din,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_data
);
  logic signed [ACC_W-1:0] avg_full;
  logic [OUT_W-1:0]        avg_n;
  logic [OUT_W-1:0]        corr;
  logic [2:0]              phase;
  logic                    keep;

  assign avg_full = $signed(base_sum) >>> l_q;
  assign avg_n    = avg_full[OUT_W-1:0];
  assign corr     = {din[SAMPLE_W-1], din} - avg_n;
  assign keep     = ((phase & keep_mask(dec_q)) == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (start) begin
      phase <= '0;
    end else if (take) begin
      phase <= phase + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take && keep) begin
      out_valid <= 1'b1;
      out_data  <= corr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bci_sequencer.sv
module bci_sequencer
  import bci_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_LOG2  = 10,
  localparam int LOG2_W   = $clog2(MAX_LOG2 + 1),
  localparam int ACC_W    = SAMPLE_W + MAX_LOG2 + 1,
  localparam int OUT_W    = SAMPLE_W + 1,
  localparam int RES_W    = ACC_W + 1,
  localparam int N_WIN    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_req,
  input  logic                beam_sync,
  input  logic [LOG2_W-1:0]   win_log2,
  input  logic [1:0]          dec_sel,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                cor_valid,
  input  logic                cor_ready,
  output logic [OUT_W-1:0]    cor_data,
  output logic                res_valid,
  output logic [RES_W-1:0]    res_intensity,
  output logic                armed,
  output logic                busy,
  output logic                missed_trig
);
  seq_state_e        state;
  logic [LOG2_W-1:0] l_q;
  logic [1:0]        dec_q;
  logic              start;
  logic              accept;
  logic [N_WIN-1:0]  win_open;
  logic [ACC_W-1:0]  sums [N_WIN];

  assign smp_ready = !((state == ST_BEAM) && cor_valid && !cor_ready);
  assign accept    = smp_valid && smp_ready;
  assign win_open  = {state == ST_BEAM, state == ST_BASE};
  assign armed     = (state == ST_ARMED);
  assign busy      = (state == ST_BASE) || (state == ST_BEAM);

  bci_ctrl #(
    .MAX_LOG2 (MAX_LOG2),
    .LOG2_W   (LOG2_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_req   (arm_req),
    .beam_sync (beam_sync),
    .win_log2  (win_log2),
    .dec_sel   (dec_sel),
    .accept    (accept),
    .state     (state),
    .l_q       (l_q),
    .dec_q     (dec_q),
    .start     (start),
    .done      (res_valid),
    .missed    (missed_trig)
  );

  // index 0 integrates the baseline window, index 1 the beam window
  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    bci_window_acc #(
      .SAMPLE_W (SAMPLE_W),
      .ACC_W    (ACC_W)
    ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .en    (win_open[g] && accept),
      .din   (smp_data),
      .sum   (sums[g])
    );
  end

  assign res_intensity = {sums[1][ACC_W-1], sums[1]} - {sums[0][ACC_W-1], sums[0]};

  bci_corr_stream #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .LOG2_W   (LOG2_W)
  ) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .take      (win_open[1] && accept),
    .l_q       (l_q),
    .dec_q     (dec_q),
    .base_sum  (sums[0]),
    .din       (smp_data),
    .out_ready (cor_ready),
    .out_valid (cor_valid),
    .out_data  (cor_data)
  );
endmodule

// File: rtl/bci_sequencer_chk.sv
module bci_sequencer_chk #(
  parameter int OUT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_req,
  input logic             beam_sync,
  input logic             cor_valid,
  input logic             cor_ready,
  input logic [OUT_W-1:0] cor_data,
  input logic             res_valid,
  input logic             armed,
  input logic             busy,
  input logic             missed_trig
);
  p_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !busy && arm_req) |=> armed);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && beam_sync) |=> (busy && !armed));

  p_res_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_valid && !cor_ready) |=> (cor_valid && $stable(cor_data)));

  p_idle_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!busy && !armed));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !busy && beam_sync) |=> !busy);

  p_missed_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_sync && !armed) |=> missed_trig);

  p_missed_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_trig && !arm_req) |=> missed_trig);
endmodule

bind bci_sequencer bci_sequencer_chk #(.OUT_W(SAMPLE_W + 1)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_req     (arm_req),
  .beam_sync   (beam_sync),
  .cor_valid   (cor_valid),
  .cor_ready   (cor_ready),
  .cor_data    (cor_data),
  .res_valid   (res_valid),
  .armed       (armed),
  .busy        (busy),
  .missed_trig (missed_trig)
);

// File: tb/bci_sequencer_tb.sv
module bci_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 16;
  localparam int MAXL = 10;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int OW   = SW + 1;
  localparam int RW   = SW + MAXL + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm_req = 1'b0, beam_sync = 1'b0;
  logic [LW-1:0] win_log2 = '0;
  logic [1:0]    dec_sel = '0;
  logic          smp_valid = 1'b0, cor_ready = 1'b1;
  logic [SW-1:0] smp_data = '0;
  logic          smp_ready, cor_valid, res_valid, armed, busy, missed_trig;
  logic [OW-1:0] cor_data;
  logic [RW-1:0] res_intensity;

  int n_tests = 0, n_fail = 0;
  int vprob = 100, rprob = 100;
  int bias = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bci_sequencer #(.SAMPLE_W(SW), .MAX_LOG2(MAXL)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .beam_sync(beam_sync),
    .win_log2(win_log2), .dec_sel(dec_sel), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .cor_valid(cor_valid),
    .cor_ready(cor_ready), .cor_data(cor_data), .res_valid(res_valid),
    .res_intensity(res_intensity), .armed(armed), .busy(busy),
    .missed_trig(missed_trig)
  );

  // behavioural reference: 0 idle, 1 armed, 2 baseline, 3 beam
  int     m_st = 0, m_cnt = 0, m_len = 1, m_n = 1;
  longint m_base = 0, m_beam = 0, m_out_d = 0;
  bit     m_out_v = 0, m_res_v = 0, m_missed = 0;

  function automatic bit m_ready();
    return !((m_st == 3) && m_out_v && !cor_ready);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_base = 0; m_beam = 0;
      m_out_v = 0; m_res_v = 0; m_missed = 0; m_out_d = 0;
    end else begin
      bit     acc;
      longint d;
      int     st0;
      acc = smp_valid && m_ready();
      d   = longint'($signed(smp_data));
      st0 = m_st;
      m_res_v = 0;
      if (beam_sync && st0 != 1) m_missed = 1;
      else if (arm_req && st0 == 0) m_missed = 0;
      if (st0 == 3 && acc && (m_cnt % m_n) == 0) begin
        m_out_v = 1;
        m_out_d = d - (m_base >>> $clog2(m_len));
      end else if (cor_ready) begin
        m_out_v = 0;
      end
      case (st0)
        0: if (arm_req) m_st = 1;
        1: if (beam_sync) begin
             int l;
             l = (int'(win_log2) > MAXL) ? MAXL : int'(win_log2);
             m_len = 1 << l; m_n = 1 << dec_sel;
             m_st = 2; m_cnt = 0; m_base = 0; m_beam = 0;
           end
        2: if (acc) begin
             m_base += d;
             if (m_cnt == m_len - 1) begin m_st = 3; m_cnt = 0; end
             else m_cnt++;
           end
        default: if (acc) begin
             m_beam += d;
             if (m_cnt == m_len - 1) begin m_st = 0; m_cnt = 0; m_res_v = 1; end
             else m_cnt++;
           end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model, then drive the next stream cycle
  task automatic tick();
    @(negedge clk);
    check(armed == (m_st == 1), "R1 armed", armed, m_st == 1);
    check(busy == (m_st >= 2), "R2 busy", busy, m_st >= 2);
    check(smp_ready == m_ready(), "R6 smp_ready", smp_ready, m_ready());
    check(cor_valid == m_out_v, "R5 cor_valid", cor_valid, m_out_v);
    if (m_out_v)
      check(longint'($signed(cor_data)) == m_out_d, "R4 cor_data",
            longint'($signed(cor_data)), m_out_d);
    check(res_valid == m_res_v, "R3 res_valid", res_valid, m_res_v);
    if (m_res_v)
      check(longint'($signed(res_intensity)) == m_beam - m_base, "R3 res_intensity",
            longint'($signed(res_intensity)), m_beam - m_base);
    check(missed_trig == m_missed, "R8 missed_trig", missed_trig, m_missed);
    smp_valid = ($urandom % 100) < vprob;
    cor_ready = ($urandom % 100) < rprob;
    smp_data  = SW'(bias + int'($urandom % 4096) - 2048);
  endtask

  task automatic pulse_arm();
    arm_req = 1'b1; tick(); arm_req = 1'b0;
  endtask

  task automatic pulse_sync();
    beam_sync = 1'b1; tick(); beam_sync = 1'b0;
  endtask

  task automatic shot(input int l, input int ds, input int vp, input int rp, input bit disturb);
    vprob = vp; rprob = rp;
    win_log2 = LW'(l); dec_sel = 2'(ds);
    pulse_arm();
    pulse_sync();
    if (disturb) begin
      // R10: reconfigure and retrigger in the middle of the shot
      repeat (3) tick();
      win_log2 = '0; dec_sel = 2'd0;
      pulse_sync();
    end
    for (int i = 0; i < 20000 && m_st != 0; i++) tick();
    rprob = 100;
    repeat (4) tick();
  endtask

  initial begin
    repeat (3) tick();
    // R9 reset state
    check(!armed && !busy && !missed_trig && !cor_valid && !res_valid && smp_ready,
          "R9 reset", {armed, busy, missed_trig, cor_valid, res_valid, smp_ready}, 6'b000001);
    rst_n = 1'b1;
    tick();
    pulse_sync();
    tick();
    check(missed_trig == 1'b1, "R8 unarmed sync", missed_trig, 1);
    bias = 300;
    shot(2, 0, 100, 100, 0);
    bias = -700;
    shot(3, 1, 70, 50, 0);
    // R7: sync after completion without arm starts nothing
    pulse_sync();
    tick();
    check(!busy && !armed, "R7 no restart", busy, 0);
    bias = 1500;
    shot(1, 3, 80, 30, 0);
    bias = -20;
    shot(0, 2, 60, 60, 0);
    bias = 50;
    shot(4, 2, 90, 40, 1);
    bias = -3000;
    shot(15, 3, 90, 90, 0);
    bias = 0;
    shot(5, 1, 100, 5, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule